// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag Controller

This block keeps the interrupt status and enable state of a real-time clock and drives one interrupt line. Three event sources feed it as single-cycle strobes: a periodic tick, an alarm match and the end of an update cycle. Each strobe sets its own flag. A flag counts toward the interrupt only while its enable bit is set. The time counters, the rate divider and the battery-backed RAM are outside the block.

A host reaches two registers over a simple read and write strobe interface. The control register sits at address 0xB and holds the three enable bits along with general-purpose bits. The status register sits at address 0xC. Reading it returns every flag and clears all of them. A chip-level reset input clears the interrupt state, and the battery-good input selects how much else that reset clears. A reset taken while the battery is low wipes the control register, locks out the host and floats the interrupt pin until a reset arrives with the battery good.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: A strobe on `evt_update`, `evt_alarm` or `evt_periodic` sets its flag whatever its enable bit holds. The flags read back in status bits 4, 5 and 6 respectively, and status bits 3:0 always read 0.
- R2: Status bit 7 (summary request) reads 1 exactly when at least one flag is set together with its enable. The enables for update, alarm and periodic are control bits 4, 5 and 6.
- R3: When inversion is off, `irq_out` is high while any flag is set together with its enable, and low otherwise. It changes in the cycle after the strobe.
- R4: A host read of address 0xC returns the current status combinationally in the same cycle, and all flags are 0 from the next cycle on.
- R5: A strobe that arrives in the same cycle as a status read leaves its flag set after that read.
- R6: `sys_reset` with `batt_ok`=1 clears control bits 6:4 and all flags and keeps control bits 7 and 3:0.
- R7: `sys_reset` with `batt_ok`=0 clears the whole control register and all flags to 0.
- R8: After a reset taken with the battery low, host writes are ignored and reads return 0x00. This lasts until a reset is taken with `batt_ok`=1.
- R9: `irq_oe` is 0 while the host is locked out (R8) and 1 otherwise.
- R10: With `irq_route_8`=1 and `irq_invert`=1, `irq_out` is the complement of the R3 level. With either of them 0, it is not inverted.
- R11: A write to address 0xB stores all 8 bits, which read back at 0xB. A read of any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous active low |
| sys_reset | input | 1 | Chip reset, synchronous active high |
| batt_ok | input | 1 | Battery above threshold |
| evt_periodic | input | 1 | Periodic tick strobe |
| evt_alarm | input | 1 | Alarm match strobe |
| evt_update | input | 1 | Update-ended strobe |
| reg_sel | input | 4 | Register address |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, valid with reg_rd |
| irq_route_8 | input | 1 | Interrupt routed to line 8 |
| irq_invert | input | 1 | Invert polarity when routed to line 8 |
| irq_out | output | 1 | Interrupt level |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The bench sweeps all 64 pairs of set flags and enable bits. For each pair it checks the pin, the summary bit and the clear-on-read. A design that gated flag setting by its enable, or that let an unenabled flag drive the summary bit, fails here. A strobe sent in the same cycle as a status read must survive the read; a design that gives the clear priority loses it. The two reset flavours are told apart by the control bits that a good-battery reset must keep. During the lockout, a write is attempted and then looked for after unlocking, which exposes a design that still accepts host writes while the battery is low.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int DW       = 8;
  localparam int AW       = 4;
  localparam int NSRC     = 3;
  localparam int SRC_LSB  = 4;
  localparam int SUM_BIT  = 7;
  localparam logic [AW-1:0] ADDR_CTRL = 4'hB;
  localparam logic [AW-1:0] ADDR_STAT = 4'hC;
  localparam logic [DW-1:0] ENA_MASK  = ((DW'(1) << NSRC) - DW'(1)) << SRC_LSB;

  typedef enum logic [1:0] {
    SRC_UPDATE   = 2'd0,
    SRC_ALARM    = 2'd1,
    SRC_PERIODIC = 2'd2
  } src_e;

  typedef struct packed {
    logic       wr_ctrl;
    logic       rd_ctrl;
    logic       rd_stat;
  } host_op_t;
endpackage

// File: rtl/rtc_irq_access.sv
module rtc_irq_access
  import rtc_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_reset,
  input  logic          batt_ok,
  input  logic [AW-1:0] reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  output logic          locked,
  output host_op_t      op
);
  logic lock_q, lock_d;
  logic open_access;

  always_comb begin
    lock_d = lock_q;
    if (sys_reset) lock_d = ~batt_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_d;
  end

  assign locked      = lock_q;
  assign open_access = ~lock_q & ~sys_reset;

  always_comb begin
    op.wr_ctrl = open_access & reg_wr & (reg_sel == ADDR_CTRL);
    op.rd_ctrl = open_access & reg_rd & (reg_sel == ADDR_CTRL);
    op.rd_stat = open_access & reg_rd & (reg_sel == ADDR_STAT);
  end
endmodule

// File: rtl/rtc_irq_ctrlreg.sv
module rtc_irq_ctrlreg
  import rtc_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_reset,
  input  logic          batt_ok,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl,
  output logic [NSRC-1:0] enables
);
  logic [DW-1:0] ctrl_q, ctrl_d;
  logic          ctrl_en;

  assign ctrl_en = sys_reset | we;

  always_comb begin
    ctrl_d = ctrl_q;
    if (sys_reset) begin
      if (batt_ok) ctrl_d = ctrl_q & ~ENA_MASK;
      else         ctrl_d = '0;
    end else if (we) begin
      ctrl_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  assign ctrl    = ctrl_q;
  assign enables = ctrl_q[SRC_LSB +: NSRC];
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sys_reset,
  input  logic            rd_clear,
  input  logic [NSRC-1:0] events,
  input  logic [NSRC-1:0] enables,
  output logic [NSRC-1:0] flags,
  output logic            summary
);
  logic [NSRC-1:0] flag_q, flag_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_comb begin
      if (sys_reset)     flag_d[i] = 1'b0;
      else if (rd_clear) flag_d[i] = events[i];
      else               flag_d[i] = flag_q[i] | events[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_d[i];
    end
  end

  assign flags   = flag_q;
  assign summary = |(flag_q & enables);
endmodule

// File: rtl/rtc_irq_pin.sv
module rtc_irq_pin (
  input  logic summary,
  input  logic locked,
  input  logic route_8,
  input  logic invert,
  output logic irq_out,
  output logic irq_oe
);
  logic flip;

  assign flip    = route_8 & invert;
  assign irq_out = summary ^ flip;
  assign irq_oe  = ~locked;
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_reset,
  input  logic          batt_ok,
  input  logic          evt_periodic,
  input  logic          evt_alarm,
  input  logic          evt_update,
  input  logic [AW-1:0] reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          irq_route_8,
  input  logic          irq_invert,
  output logic          irq_out,
  output logic          irq_oe
);
  host_op_t        op;
  logic            locked;
  logic [DW-1:0]   ctrl;
  logic [NSRC-1:0] enables;
  logic [NSRC-1:0] events;
  logic [NSRC-1:0] flags;
  logic            summary;
  logic [DW-1:0]   status;

  always_comb begin
    events = '0;
    events[SRC_UPDATE]   = evt_update;
    events[SRC_ALARM]    = evt_alarm;
    events[SRC_PERIODIC] = evt_periodic;
  end

  rtc_irq_access u_access (
    .clk(clk), .rst_n(rst_n), .sys_reset(sys_reset), .batt_ok(batt_ok),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .locked(locked), .op(op)
  );

  rtc_irq_ctrlreg u_ctrl (
    .clk(clk), .rst_n(rst_n), .sys_reset(sys_reset), .batt_ok(batt_ok),
    .we(op.wr_ctrl), .wdata(reg_wdata), .ctrl(ctrl), .enables(enables)
  );

  rtc_irq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .sys_reset(sys_reset), .rd_clear(op.rd_stat),
    .events(events), .enables(enables), .flags(flags), .summary(summary)
  );

  rtc_irq_pin u_pin (
    .summary(summary), .locked(locked), .route_8(irq_route_8),
    .invert(irq_invert), .irq_out(irq_out), .irq_oe(irq_oe)
  );

  always_comb begin
    status = '0;
    status[SRC_LSB +: NSRC] = flags;
    status[SUM_BIT]         = summary;
  end

  always_comb begin
    reg_rdata = '0;
    if (op.rd_ctrl)      reg_rdata = ctrl;
    else if (op.rd_stat) reg_rdata = status;
  end
endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk
  import rtc_irq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            sys_reset,
  input logic            batt_ok,
  input logic            evt_periodic,
  input logic            evt_alarm,
  input logic            evt_update,
  input logic [AW-1:0]   reg_sel,
  input logic            reg_rd,
  input logic            reg_wr,
  input logic            irq_oe,
  input logic            locked,
  input logic [DW-1:0]   ctrl,
  input logic [NSRC-1:0] flags
);
  logic stat_read;
  assign stat_read = reg_rd && !locked && !sys_reset && (reg_sel == ADDR_STAT);

  AST_EVT_SETS_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_reset && evt_alarm) |=> flags[SRC_ALARM]);                            // R1
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_read && !evt_periodic && !evt_alarm && !evt_update) |=> (flags == '0)); // R4
  AST_READ_KEEPS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_read && evt_periodic) |=> flags[SRC_PERIODIC]);                       // R5
  AST_GOOD_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_reset && batt_ok) |=> ((ctrl & ENA_MASK) == '0 && flags == '0 && !locked)); // R6
  AST_LOW_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_reset && !batt_ok) |=> (ctrl == '0 && flags == '0));                   // R7
  AST_LOCK_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !sys_reset && reg_wr) |=> $stable(ctrl));                        // R8
  AST_LOCK_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_reset && !batt_ok) |=> !irq_oe);                                        // R9
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sys_reset(sys_reset), .batt_ok(batt_ok),
  .evt_periodic(evt_periodic), .evt_alarm(evt_alarm), .evt_update(evt_update),
  .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr), .irq_oe(irq_oe),
  .locked(locked), .ctrl(ctrl), .flags(flags)
);

// File: tb/rtc_irq_ctrl_test.sv
`timescale 1ns/1ps
module rtc_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n, sys_reset, batt_ok;
  logic       evt_periodic, evt_alarm, evt_update;
  logic [3:0] reg_sel;
  logic       reg_wr, reg_rd;
  logic [7:0] reg_wdata, reg_rdata;
  logic       irq_route_8, irq_invert, irq_out, irq_oe;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rtc_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sys_reset(sys_reset), .batt_ok(batt_ok),
    .evt_periodic(evt_periodic), .evt_alarm(evt_alarm), .evt_update(evt_update),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_route_8(irq_route_8), .irq_invert(irq_invert),
    .irq_out(irq_out), .irq_oe(irq_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_sel = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] f);
    evt_update = f[0]; evt_alarm = f[1]; evt_periodic = f[2];
    @(negedge clk);
    evt_update = 1'b0; evt_alarm = 1'b0; evt_periodic = 1'b0;
  endtask

  task automatic chip_reset(input logic good);
    batt_ok = good; sys_reset = 1'b1;
    @(negedge clk);
    sys_reset = 1'b0; batt_ok = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; sys_reset = 1'b0; batt_ok = 1'b1;
    evt_periodic = 1'b0; evt_alarm = 1'b0; evt_update = 1'b0;
    reg_sel = 4'h0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = 8'h00;
    irq_route_8 = 1'b0; irq_invert = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R3 reset irq_out", {7'd0, irq_out}, 8'h00);
    check("R9 reset irq_oe", {7'd0, irq_oe}, 8'h01);
    rd(4'hC, d); check("R4 reset status", d, 8'h00);
    rd(4'hB, d); check("R11 reset ctrl", d, 8'h00);

    // Full sweep of flag pattern x enable pattern: R1 R2 R3 R4
    for (int e = 0; e < 8; e++) begin
      for (int f = 0; f < 8; f++) begin
        logic s;
        s = |(3'(f) & 3'(e));
        wr(4'hB, {1'b0, 3'(e), 4'h5});
        pulse(3'(f));
        check("R3 irq level", {7'd0, irq_out}, {7'd0, s});
        rd(4'hC, d);
        check("R1 R2 status", d, {s, 3'(f), 4'h0});
        check("R4 irq after clear", {7'd0, irq_out}, 8'h00);
        rd(4'hC, d);
        check("R4 status cleared", d, 8'h00);
      end
    end

    // R11 readback and unused address
    wr(4'hB, 8'hA6); rd(4'hB, d); check("R11 ctrl readback", d, 8'hA6);
    rd(4'h3, d); check("R11 other address", d, 8'h00);

    // R5 event in the same cycle as a status read
    wr(4'hB, 8'h70);
    pulse(3'b100);
    reg_sel = 4'hC; reg_rd = 1'b1; evt_alarm = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; evt_alarm = 1'b0;
    check("R5 read sees periodic", d, 8'hC0);
    rd(4'hC, d); check("R5 alarm kept", d, 8'hA0);

    // R10 polarity
    irq_route_8 = 1'b1; irq_invert = 1'b1; #1;
    check("R10 inverted idle", {7'd0, irq_out}, 8'h01);
    pulse(3'b001); #1;
    check("R10 inverted active", {7'd0, irq_out}, 8'h00);
    irq_route_8 = 1'b0; #1;
    check("R10 not routed", {7'd0, irq_out}, 8'h01);
    irq_route_8 = 1'b1; irq_invert = 1'b0; #1;
    check("R10 routed no invert", {7'd0, irq_out}, 8'h01);
    irq_route_8 = 1'b0;
    rd(4'hC, d);

    // R6 good-battery reset
    wr(4'hB, 8'hFA);
    pulse(3'b111);
    chip_reset(1'b1);
    check("R6 irq after reset", {7'd0, irq_out}, 8'h00);
    rd(4'hB, d); check("R6 ctrl kept bits", d, 8'h8A);
    rd(4'hC, d); check("R6 flags cleared", d, 8'h00);
    check("R9 oe after good reset", {7'd0, irq_oe}, 8'h01);

    // R7 R8 R9 low-battery reset and lockout
    wr(4'hB, 8'hFF);
    pulse(3'b111);
    chip_reset(1'b0);
    check("R9 oe locked", {7'd0, irq_oe}, 8'h00);
    check("R7 irq after low reset", {7'd0, irq_out}, 8'h00);
    rd(4'hB, d); check("R8 locked ctrl read", d, 8'h00);
    wr(4'hB, 8'h0F);
    pulse(3'b010);
    rd(4'hC, d); check("R8 locked status read", d, 8'h00);
    chip_reset(1'b1);
    check("R9 oe unlocked", {7'd0, irq_oe}, 8'h01);
    rd(4'hB, d); check("R7 R8 ctrl zero and write ignored", d, 8'h00);
    rd(4'hC, d); check("R6 flags cleared on unlock", d, 8'h00);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule